// File: doc/BRIEF.md
# SDRAM Read-Burst Truncation Scheduler

This block sits beside the command sequencer of an SDRAM controller and owns the cycles that follow a READ. The controller launches a read through the block, which puts the READ code on the command bus and then tracks the burst: its CAS latency, its length (1, 2, 4 or 8 beats, or full page), its bank and whether auto precharge was requested. While the read is in flight the controller may ask for a follow-up command, which is a WRITE, a PRECHARGE to the read's bank or a BURST TERMINATE. With the request it gives the index of the last data beat it still wants. The block works out the cycle in which that command must go out, drives NOP on every other cycle, and raises the data mask early enough that read data cannot collide with write data.

The follow-up request is a valid/ready channel. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The READ launch is also qualified by `req_ready`. `req_ready` falls in the cycle after a command is accepted for scheduling and stays low until that command has been driven. After a PRECHARGE it also stays low until the row precharge time has elapsed. A request that cannot be honoured is still consumed. It ends in a one-cycle `rej` pulse if it is not allowed, or a one-cycle `late` pulse if it came too late, and in either case the read runs to its natural end.

Offsets below count cycles from the READ command, which is offset 0. Beat k of the read is on the data bus at offset CL+k. Le is the effective last beat.

Top module: `rd_trunc_sched`

## Requirements
- R1: After reset, `cmd` is NOP (4'b0111), `dqm`, `late` and `rej` are low and `req_ready` is high. NOP is driven on every cycle that has no scheduled command.
- R2: When `rd_start` and `req_ready` are both high, `cmd` is READ (4'b0101) in that same cycle and `cmd_bank` equals `rd_bank`. The burst length code gives 2^code beats, and `rd_full_page` selects an open-ended burst.
- R3: An accepted PRECHARGE (`req_kind`=1) or BURST TERMINATE (`req_kind`=2) is driven as 4'b0010 or 4'b0110 at offset Le+1, which is CL-1 cycles before the edge at which beat Le is valid. `cmd_bank` carries the read's bank.
- R4: An accepted WRITE (`req_kind`=0) is driven as 4'b0100 at offset CL+Le+1, or CL+Le+2 when `nop_gap` is high, and `dqm` is low in that cycle.
- R5: For an accepted WRITE, `dqm` is high from offset CL+Le-1 up to the cycle before the WRITE, so it is high at least two cycles before it. `dqm` is low in all other cycles.
- R6: After a PRECHARGE at cycle p, `req_ready` is low in cycles p+1 to p+TRP-1 and no command other than NOP is driven there. A READ can launch at p+TRP.
- R7: A PRECHARGE or BURST TERMINATE request against a fixed-length read with auto precharge produces a `rej` pulse in the next cycle and no command. A full-page read accepts both commands whatever the state of `rd_autopre`.
- R8: A request whose lead time is already gone produces a `late` pulse in the next cycle and no command. This applies when Le+1 is not beyond the request offset for PRECHARGE or TERMINATE, and when CL+Le-1 is not beyond it for WRITE.
- R9: For a fixed-length read, a requested last beat beyond the burst is clamped to the burst's final beat.
- R10: A request with no read in flight produces a `rej` pulse. This includes a request in the READ cycle itself, and one after the last beat of a fixed burst at offset CL+beats-1.
- R11: `req_ready` is low from the cycle after a command is accepted for scheduling through the cycle that command is driven. A request or `rd_start` offered then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| nop_gap | input | 1 | Insert one idle cycle before a WRITE |
| rd_start | input | 1 | Launch a READ this cycle |
| rd_bank | input | BANK_W | Bank of the READ |
| rd_len_code | input | 2 | Burst length code, 2^code beats |
| rd_full_page | input | 1 | Open-ended full-page burst |
| rd_autopre | input | 1 | READ carries auto precharge |
| req_valid | input | 1 | Follow-up request valid |
| req_ready | output | 1 | Request or launch may be taken |
| req_kind | input | 2 | 0 WRITE, 1 PRECHARGE, 2 BURST TERMINATE |
| req_last | input | BEAT_W | Index of last wanted beat |
| cmd | output | 4 | Command code {CS#,RAS#,CAS#,WE#} |
| cmd_bank | output | BANK_W | Bank of the driven command |
| dqm | output | 1 | Data mask pin |
| late | output | 1 | Request came too late, pulse |
| rej | output | 1 | Request not allowed, pulse |

## Verification
On every cycle, the assertions check three things about the command stream. The mask is low on a WRITE and was high on the two cycles before it. The precharge window holds only NOPs. No READ appears while the block is busy, and `late` and `rej` never pulse together. The exact offsets of each truncating command for each CAS latency, the clamping of the last beat, and the refusal and late-arrival cases are shown only by the bench scenarios. There, a behavioural model predicts every output cycle by cycle.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_BST   = 4'b0110
  } sdr_cmd_e;

  localparam logic [1:0] KIND_WRITE = 2'd0;
  localparam logic [1:0] KIND_PRE   = 2'd1;
  localparam logic [1:0] KIND_BST   = 2'd2;
endpackage

// File: rtl/rts_read_track.sv
module rts_read_track
  import rts_pkg::*;
#(
  parameter int BEAT_W = 9,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [1:0]        len_code,
  input  logic              full_page,
  input  logic              autopre,
  input  logic [1:0]        cas_lat,
  input  logic              hold,
  input  logic              done,
  output logic              act,
  output logic [CNT_W-1:0]  cnt,
  output logic [BANK_W-1:0] bank_r,
  output logic              fp_r,
  output logic              ap_r,
  output logic [BEAT_W-1:0] last_r
);
  localparam int SW = CNT_W + 1;

  logic [SW-1:0] end_at;
  logic          nat_end;

  // offset of the final beat of a fixed burst
  assign end_at  = SW'(cas_lat) + SW'(last_r);
  assign nat_end = act && !fp_r && (SW'(cnt) == end_at);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= 1'b0;
      cnt    <= '0;
      bank_r <= '0;
      fp_r   <= 1'b0;
      ap_r   <= 1'b0;
      last_r <= '0;
    end else if (start) begin
      act    <= 1'b1;
      cnt    <= CNT_W'(1);
      bank_r <= bank_in;
      fp_r   <= full_page;
      ap_r   <= autopre;
      last_r <= BEAT_W'((1 << len_code) - 1);
    end else begin
      if ((act || hold) && (cnt != '1)) cnt <= cnt + 1'b1;
      if (done || nat_end) act <= 1'b0;
    end
  end
endmodule

// File: rtl/rts_plan.sv
module rts_plan
  import rts_pkg::*;
#(
  parameter int BEAT_W = 9,
  parameter int CNT_W  = 12
) (
  input  logic              start,
  input  logic              act,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              fp,
  input  logic              ap,
  input  logic [BEAT_W-1:0] last_idx,
  input  logic [1:0]        cas_lat,
  input  logic              nop_gap,
  input  logic [1:0]        kind,
  input  logic [BEAT_W-1:0] req_last,
  output logic              ok,
  output logic              late,
  output logic              rej,
  output logic              is_wr,
  output logic [CNT_W:0]    dqm_at,
  output logic [CNT_W:0]    cmd_at
);
  localparam int SW = CNT_W + 1;

  logic [BEAT_W-1:0] le;
  logic [SW-1:0]     now;
  logic              in_time;

  always_comb begin
    le = (fp || (req_last <= last_idx)) ? req_last : last_idx;
    now = SW'(cnt);
    is_wr = (kind == KIND_WRITE);
    if (is_wr) begin
      dqm_at  = SW'(cas_lat) + SW'(le);
      cmd_at  = dqm_at + SW'(1) + SW'(nop_gap);
      in_time = dqm_at > (now + SW'(1));
    end else begin
      dqm_at  = '0;
      cmd_at  = SW'(le) + SW'(1);
      in_time = cmd_at > now;
    end
    rej  = start || !act || (kind == 2'd3) || (!is_wr && ap && !fp);
    late = !rej && !in_time;
    ok   = !rej && in_time;
  end
endmodule

// File: rtl/rts_issue.sv
module rts_issue
  import rts_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TRP   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             p_ok,
  input  logic             p_late,
  input  logic             p_rej,
  input  logic             p_wr,
  input  logic [1:0]       p_kind,
  input  logic [CNT_W:0]   p_dqm_at,
  input  logic [CNT_W:0]   p_cmd_at,
  input  logic [CNT_W-1:0] cnt,
  output logic             pend,
  output logic             issue_now,
  output sdr_cmd_e         issue_cmd,
  output logic             dqm,
  output logic             ready,
  output logic             late,
  output logic             rej
);
  localparam int SW    = CNT_W + 1;
  localparam int TRP_W = $clog2(TRP + 1);

  logic [SW-1:0]    dqm_at, cmd_at;
  logic             wr_r;
  logic [TRP_W-1:0] trp_cnt;
  logic [SW-1:0]    now;

  assign now       = SW'(cnt);
  assign issue_now = pend && (now == cmd_at);
  assign dqm       = pend && wr_r && ((now + SW'(1)) >= dqm_at) && (now < cmd_at);
  assign ready     = !pend && (trp_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      wr_r      <= 1'b0;
      dqm_at    <= '0;
      cmd_at    <= '0;
      issue_cmd <= CMD_NOP;
      trp_cnt   <= '0;
      late      <= 1'b0;
      rej       <= 1'b0;
    end else begin
      late <= accept && p_late;
      rej  <= accept && p_rej;
      if (trp_cnt != '0) trp_cnt <= trp_cnt - 1'b1;
      if (accept && p_ok) begin
        pend   <= 1'b1;
        wr_r   <= p_wr;
        dqm_at <= p_dqm_at;
        cmd_at <= p_cmd_at;
        case (p_kind)
          KIND_WRITE: issue_cmd <= CMD_WRITE;
          KIND_PRE:   issue_cmd <= CMD_PRE;
          default:    issue_cmd <= CMD_BST;
        endcase
      end else if (issue_now) begin
        pend <= 1'b0;
        if (issue_cmd == CMD_PRE) trp_cnt <= TRP_W'(TRP - 1);
      end
    end
  end
endmodule

// File: rtl/rd_trunc_sched.sv
module rd_trunc_sched
  import rts_pkg::*;
#(
  parameter int BEAT_W = 9,
  parameter int BANK_W = 2,
  parameter int TRP    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cas_lat,
  input  logic              nop_gap,
  input  logic              rd_start,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [1:0]        rd_len_code,
  input  logic              rd_full_page,
  input  logic              rd_autopre,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [BEAT_W-1:0] req_last,
  output logic [3:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              dqm,
  output logic              late,
  output logic              rej
);
  localparam int CNT_W = BEAT_W + 3;

  logic              start, accept, act, fp_r, ap_r, pend, issue_now;
  logic [CNT_W-1:0]  cnt;
  logic [BANK_W-1:0] bank_r;
  logic [BEAT_W-1:0] last_r;
  logic              p_ok, p_late, p_rej, p_wr;
  logic [CNT_W:0]    p_dqm_at, p_cmd_at;
  sdr_cmd_e          issue_cmd;

  assign start  = rd_start && req_ready;
  assign accept = req_valid && req_ready;

  rts_read_track #(.BEAT_W(BEAT_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .start(start), .bank_in(rd_bank),
    .len_code(rd_len_code), .full_page(rd_full_page), .autopre(rd_autopre),
    .cas_lat(cas_lat), .hold(pend), .done(issue_now), .act(act), .cnt(cnt),
    .bank_r(bank_r), .fp_r(fp_r), .ap_r(ap_r), .last_r(last_r)
  );

  rts_plan #(.BEAT_W(BEAT_W), .CNT_W(CNT_W)) u_plan (
    .start(start), .act(act), .cnt(cnt), .fp(fp_r), .ap(ap_r),
    .last_idx(last_r), .cas_lat(cas_lat), .nop_gap(nop_gap), .kind(req_kind),
    .req_last(req_last), .ok(p_ok), .late(p_late), .rej(p_rej), .is_wr(p_wr),
    .dqm_at(p_dqm_at), .cmd_at(p_cmd_at)
  );

  rts_issue #(.CNT_W(CNT_W), .TRP(TRP)) u_issue (
    .clk(clk), .rst_n(rst_n), .accept(accept), .p_ok(p_ok), .p_late(p_late),
    .p_rej(p_rej), .p_wr(p_wr), .p_kind(req_kind), .p_dqm_at(p_dqm_at),
    .p_cmd_at(p_cmd_at), .cnt(cnt), .pend(pend), .issue_now(issue_now),
    .issue_cmd(issue_cmd), .dqm(dqm), .ready(req_ready), .late(late), .rej(rej)
  );

  always_comb begin
    cmd      = CMD_NOP;
    cmd_bank = '0;
    if (start) begin
      cmd      = CMD_READ;
      cmd_bank = rd_bank;
    end else if (issue_now) begin
      cmd      = issue_cmd;
      cmd_bank = bank_r;
    end
  end
endmodule

// File: rtl/rd_trunc_chk.sv
module rd_trunc_chk #(
  parameter int TRP = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       dqm,
  input logic       rd_start,
  input logic       req_ready,
  input logic       late,
  input logic       rej
);
  localparam int TRP_W = $clog2(TRP + 1);
  logic [TRP_W-1:0] since_pre;

  always_ff @(posedge clk) begin
    if (!rst_n) since_pre <= '0;
    else if (cmd == 4'b0010) since_pre <= TRP_W'(1);
    else if (since_pre != '0)
      since_pre <= (since_pre == TRP_W'(TRP - 1)) ? '0 : since_pre + 1'b1;
  end

  a_r4_dqm_low_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0100) |-> !dqm);
  a_r5_dqm_two_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0100) |-> ($past(dqm, 1) && $past(dqm, 2)));
  a_r6_trp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_pre != '0) |-> (cmd == 4'b0111 && !req_ready));
  a_r11_no_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !req_ready) |-> (cmd != 4'b0101));
  a_r8_late_rej_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({late, rej}));
endmodule

bind rd_trunc_sched rd_trunc_chk #(.TRP(TRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .dqm(dqm), .rd_start(rd_start),
  .req_ready(req_ready), .late(late), .rej(rej)
);

// File: tb/rd_trunc_sched_tb.sv
module rd_trunc_sched_tb;
  localparam int BEAT_W = 9;
  localparam int BANK_W = 2;
  localparam int TRP    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cas_lat = 2'd2;
  logic nop_gap = 1'b0;
  logic rd_start = 1'b0;
  logic [BANK_W-1:0] rd_bank = '0;
  logic [1:0] rd_len_code = '0;
  logic rd_full_page = 1'b0, rd_autopre = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = '0;
  logic [BEAT_W-1:0] req_last = '0;
  logic [3:0] cmd;
  logic [BANK_W-1:0] cmd_bank;
  logic dqm, late, rej;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rd_trunc_sched #(.BEAT_W(BEAT_W), .BANK_W(BANK_W), .TRP(TRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .nop_gap(nop_gap),
    .rd_start(rd_start), .rd_bank(rd_bank), .rd_len_code(rd_len_code),
    .rd_full_page(rd_full_page), .rd_autopre(rd_autopre), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_last(req_last), .cmd(cmd),
    .cmd_bank(cmd_bank), .dqm(dqm), .late(late), .rej(rej)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural model: predicts every output of a read plus one request.
  task automatic run_case(input int cl, input int gap, input int lc, input int fp,
                          input int ap, input int bank, input int kind, input int lb,
                          input int o, input bit noread, input string tag);
    int beats = 1 << lc;
    int le = (fp != 0 || lb <= beats - 1) ? lb : beats - 1;
    bit active = !noread && o >= 1 && (fp != 0 || o <= cl + beats - 1);
    bit refuse = !active || (kind != 0 && ap != 0 && fp == 0);
    int dq_from = cl + le - 1;
    int iss = (kind == 0) ? cl + le + 1 + gap : le + 1;
    bit in_time = (kind == 0) ? (dq_from > o) : (iss > o);
    bit ok = !refuse && in_time;
    bit lt = !refuse && !in_time;
    int kcmd = (kind == 0) ? 4 : (kind == 1) ? 2 : 6;
    int n = o + 3;
    if (fp == 0 && cl + beats + 2 > n) n = cl + beats + 2;
    if (ok && iss + TRP + 2 > n) n = iss + TRP + 2;
    for (int k = 0; k < n; k++) begin
      int ecmd;
      bit erdy, edqm;
      @(negedge clk);
      cas_lat = 2'(cl); nop_gap = gap[0];
      rd_start = (k == 0) && !noread;
      rd_bank = BANK_W'(bank); rd_len_code = 2'(lc);
      rd_full_page = fp[0]; rd_autopre = ap[0];
      req_valid = (k == o) || (ok && k == o + 1);  // second offer must be ignored (R11)
      req_kind = 2'(kind); req_last = BEAT_W'(lb);
      #1;
      ecmd = (k == 0 && !noread) ? 5 : (ok && k == iss) ? kcmd : 7;
      erdy = !(ok && k > o && k <= iss) && !(ok && kind == 1 && k > iss && k < iss + TRP);
      edqm = ok && kind == 0 && k >= dq_from && k < iss;
      chk((k == 0) ? "R2" : tag, "cmd", cmd, ecmd);
      if (ecmd != 7) chk(tag, "cmd_bank", cmd_bank, bank);
      chk("R5", "dqm", dqm, edqm);
      chk((kind == 1 && ok && k > iss) ? "R6" : "R11", "req_ready", req_ready, erdy);
      chk(tag, "late", late, lt && k == o + 1);
      chk(tag, "rej", rej, refuse && k == o + 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1", "cmd", cmd, 7);
    chk("R1", "dqm", dqm, 0);
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "late", late, 0);
    chk("R1", "rej", rej, 0);
    //        cl gap lc fp ap bank kind lb  o  noread
    run_case(2, 0, 3, 0, 0, 1, 1,  3, 2, 0, "R3");   // precharge, CL2
    run_case(3, 0, 2, 0, 0, 2, 2,  2, 1, 0, "R3");   // terminate, CL3
    run_case(1, 0, 3, 0, 0, 3, 1,  6, 2, 0, "R3");   // precharge, CL1
    run_case(1, 0, 3, 0, 0, 0, 1,  5, 6, 0, "R8");   // precharge too late
    run_case(2, 0, 3, 0, 0, 1, 0,  3, 2, 0, "R4");   // write, no gap
    run_case(3, 1, 3, 0, 0, 2, 0,  1, 1, 0, "R4");   // write, gap
    run_case(1, 0, 3, 0, 0, 3, 0,  4, 2, 0, "R4");   // write, CL1
    run_case(2, 0, 2, 0, 1, 0, 1,  1, 1, 0, "R7");   // precharge vs auto precharge
    run_case(2, 0, 2, 0, 1, 0, 2,  1, 1, 0, "R7");   // terminate vs auto precharge
    run_case(2, 0, 0, 1, 1, 1, 1, 20, 3, 0, "R7");   // full page still truncatable
    run_case(2, 0, 1, 0, 0, 2, 1,  7, 1, 0, "R9");   // clamp beyond 2-beat burst
    run_case(3, 0, 3, 0, 0, 0, 0,  2, 4, 0, "R8");   // write too late
    run_case(3, 0, 3, 1, 0, 3, 2, 100, 50, 0, "R3"); // full page terminate
    run_case(2, 0, 2, 0, 0, 1, 1,  2, 0, 0, "R10");  // request in READ cycle
    run_case(2, 0, 2, 0, 0, 1, 1,  2, 2, 1, "R10");  // no read in flight
    run_case(2, 0, 1, 0, 0, 1, 1,  1, 4, 0, "R10");  // after burst end
    @(negedge clk);
    rd_start = 1'b0; req_valid = 1'b0;
    finish_run();
  end
endmodule